// File: doc/BRIEF.md
# Shared Work RAM Bank Mapper for Two Processors

The mapper sits between two processor ports and a memory window that holds a shared RAM of two equal halves plus a private RAM of four banks that only the second processor can reach. A 2-bit mode register picks one of four fixed routing patterns. Each processor port has its own routing table, so the mode changes which shared half each processor sees in each slot of its window. The routing never sends both processors to the same half, so two accesses in the same cycle never collide and no arbiter is needed.

Every access is split into a slot number (the two address bits just above the unit offset) and an offset inside the unit. The slot and the mode give a target: one of the shared halves, one of the private banks, or nothing. A read from nothing returns zero. A write to nothing is dropped. The RAMs are inside the block. They take byte-lane writes and return read data one cycle after the access. The first processor writes the mode, and both processors can read it back. A boot input forces the mode that gives the whole shared RAM to the second processor.

The unit size is 2^OFS_W bytes. In the chip configuration OFS_W is 14, which gives 16 KB units. The default parameter value is smaller so that elaboration stays light. Addresses are byte addresses and data words are DW bits wide.

Top module: `wram_bank_mapper`

## Requirements
- R1: Reset clears the mode to 0. Both mode read-back ports then read 0.
- R2: A write on the control port loads bits 1:0 of cfg_wdata into the mode and ignores the upper bits. An access that starts in the same cycle as the write still uses the old mode. Accesses from the next cycle on use the new mode.
- R3: In every mode, when both ports are enabled, the two ports are never routed to the same shared half. Simultaneous accesses to the two halves both complete.
- R4: The first port (A) routes slots 0..3 by mode as follows. Mode 0: half 0, half 1, half 0, half 1. Mode 1: half 1 in every slot. Mode 2: half 0 in every slot. Mode 3: no target in any slot.
- R5: The second port (B), with address bit ADDR_W-1 clear, routes slots 0..3 by mode as follows. Mode 0: private banks 0, 1, 2, 3. Mode 1: half 0 in every slot. Mode 2: half 1 in every slot. Mode 3: half 0, half 1, half 0, half 1.
- R6: When port B sets address bit ADDR_W-1, slot s always reaches private bank s in every mode. This is the same storage that mode 0 reaches through slot s of the low region. The bank's physical address is bank number times the unit size plus the offset.
- R7: A read with no target returns all zeros. A write with no target changes no storage.
- R8: cfg_rdata (port A) and stat_rdata (port B) both read {zeros, mode}.
- R9: boot_init loads mode 3 and takes priority over a control write in the same cycle.
- R10: Write byte lane i (bits 8i+7:8i) changes only when be[i] is set.
- R11: Read data is valid on the port's rdata in the cycle after the read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_init | input | 1 | Forces mode 3 |
| cfg_we | input | 1 | Mode write strobe (port A side) |
| cfg_wdata | input | 8 | Mode write byte; bits 1:0 are used |
| cfg_rdata | output | 8 | Mode read-back for port A |
| stat_rdata | output | 8 | Mode status for port B |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write (1) / read (0) |
| a_be | input | DW/8 | Port A byte enables |
| a_addr | input | ADDR_W | Port A byte address in the window |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A read data, one cycle after the access |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write (1) / read (0) |
| b_be | input | DW/8 | Port B byte enables |
| b_addr | input | ADDR_W | Port B byte address; top bit selects the high region |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B read data, one cycle after the access |

## Verification
The hardest case to reach from the ports is aliasing: the same physical half or bank reached through different slots, different modes and different ports. An error there leaves each single access looking correct. The stimulus tags every reachable target with a distinct value, changes the mode, and then reads every slot of both ports against a storage model. A wrong route therefore shows up as a stale or foreign value. Directed cases also drive both ports in the same cycle, a control write in the same cycle as an access, and boot_init together with a control write.

// File: rtl/wram_map_pkg.sv
package wram_map_pkg;

   typedef enum logic [1:0] {
      K_SHARED = 2'd0,
      K_PRIV   = 2'd1,
      K_NONE   = 2'd2
   } kind_e;

   typedef struct packed {
      kind_e      kind;
      logic [1:0] bank;
   } tgt_t;

   // Routing for the first port: shared halves only, mode 3 hides them.
   function automatic tgt_t map_first(input logic [1:0] mode, input logic [1:0] slot);
      tgt_t t;
      t.kind = K_SHARED;
      t.bank = 2'd0;
      case (mode)
         2'd0:    t.bank = {1'b0, slot[0]};
         2'd1:    t.bank = 2'd1;
         2'd2:    t.bank = 2'd0;
         default: t.kind = K_NONE;
      endcase
      return t;
   endfunction

   // Routing for the second port: high region always private.
   function automatic tgt_t map_second(input logic [1:0] mode, input logic [1:0] slot,
                                       input logic hi);
      tgt_t t;
      t.kind = K_SHARED;
      t.bank = 2'd0;
      if (hi || mode == 2'd0) begin
         t.kind = K_PRIV;
         t.bank = slot;
      end else begin
         case (mode)
            2'd1:    t.bank = 2'd0;
            2'd2:    t.bank = 2'd1;
            default: t.bank = {1'b0, slot[0]};
         endcase
      end
      return t;
   endfunction

endpackage

// File: rtl/wram_mode_reg.sv
module wram_mode_reg #(
   parameter int MODE_W    = 2,
   parameter int CFG_W     = 8,
   parameter int BOOT_MODE = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boot_init,
   input  logic              wr_en,
   input  logic [CFG_W-1:0]  wr_data,
   output logic [MODE_W-1:0] mode
);

   initial begin
      if (CFG_W < MODE_W) $error("wram_mode_reg: CFG_W must hold the mode");
      if (BOOT_MODE >= (1 << MODE_W)) $error("wram_mode_reg: BOOT_MODE out of range");
   end

   localparam logic [MODE_W-1:0] BOOT_VAL = MODE_W'(BOOT_MODE);

   logic unused_hi;
   assign unused_hi = ^wr_data[CFG_W-1:MODE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mode <= '0;
      else if (boot_init) mode <= BOOT_VAL;
      else if (wr_en)     mode <= wr_data[MODE_W-1:0];
   end

endmodule

// File: rtl/wram_slot_decode.sv
module wram_slot_decode
   import wram_map_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int OFS_W  = 9,
   parameter int DW     = 32,
   parameter bit SECOND = 1'b0,
   localparam int LANE_BITS = $clog2(DW / 8),
   localparam int WIDX_W    = OFS_W - LANE_BITS
) (
   input  logic [1:0]        mode,
   input  logic [ADDR_W-1:0] addr,
   output tgt_t              tgt,
   output logic [WIDX_W-1:0] widx
);

   initial begin
      if (ADDR_W < OFS_W + 3) $error("wram_slot_decode: ADDR_W too small");
   end

   logic [1:0] slot;
   assign slot = addr[OFS_W+1:OFS_W];
   assign widx = addr[OFS_W-1:LANE_BITS];

   generate
      if (SECOND) begin : g_second
         assign tgt = map_second(mode, slot, addr[ADDR_W-1]);
      end else begin : g_first
         assign tgt = map_first(mode, slot);
      end
      if (LANE_BITS > 0) begin : g_lane_unused
         logic unused_lane;
         assign unused_lane = ^addr[LANE_BITS-1:0];
      end
   endgenerate

   logic unused_top;
   assign unused_top = ^addr[ADDR_W-1:OFS_W+2];

endmodule

// File: rtl/wram_bank.sv
module wram_bank #(
   parameter int DW    = 32,
   parameter int DEPTH = 128,
   localparam int BE_W = DW / 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            en,
   input  logic            we,
   input  logic [BE_W-1:0] be,
   input  logic [AW-1:0]   widx,
   input  logic [DW-1:0]   wdata,
   output logic [DW-1:0]   rdata
);

   initial begin
      if (DW % 8 != 0) $error("wram_bank: DW must be a whole number of bytes");
      if ((1 << AW) != DEPTH) $error("wram_bank: DEPTH must be a power of two");
   end

   generate
      for (genvar i = 0; i < BE_W; i++) begin : g_lane
         logic [7:0] mem [DEPTH];
         logic [7:0] rd_q;
         always_ff @(posedge clk) begin
            if (en && we && be[i]) mem[widx] <= wdata[i*8 +: 8];
            if (en && !we)         rd_q      <= mem[widx];
         end
         assign rdata[i*8 +: 8] = rd_q;
      end
   endgenerate

endmodule

// File: rtl/wram_bank_mapper.sv
module wram_bank_mapper
   import wram_map_pkg::*;
#(
   parameter int DW     = 32,
   parameter int ADDR_W = 24,
   parameter int OFS_W  = 9,
   localparam int BE_W  = DW / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boot_init,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   output logic [7:0]        stat_rdata,
   input  logic              a_en,
   input  logic              a_we,
   input  logic [BE_W-1:0]   a_be,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DW-1:0]     a_wdata,
   output logic [DW-1:0]     a_rdata,
   input  logic              b_en,
   input  logic              b_we,
   input  logic [BE_W-1:0]   b_be,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DW-1:0]     b_wdata,
   output logic [DW-1:0]     b_rdata
);

   localparam int LANE_BITS = $clog2(BE_W);
   localparam int WIDX_W    = OFS_W - LANE_BITS;
   localparam int DEPTH     = 1 << WIDX_W;
   localparam int N_SH      = 2;
   localparam int N_PV      = 4;

   initial begin
      if (DW < 8 || (DW % 8) != 0) $error("wram_bank_mapper: bad DW");
      if (OFS_W <= LANE_BITS)      $error("wram_bank_mapper: OFS_W too small");
   end

   logic [1:0] mode;

   wram_mode_reg #(.MODE_W(2), .CFG_W(8), .BOOT_MODE(3)) mode_i (
      .clk(clk), .rst_n(rst_n), .boot_init(boot_init),
      .wr_en(cfg_we), .wr_data(cfg_wdata), .mode(mode)
   );

   assign cfg_rdata  = {6'b0, mode};
   assign stat_rdata = {6'b0, mode};

   tgt_t              a_tgt, b_tgt;
   logic [WIDX_W-1:0] a_widx, b_widx;

   wram_slot_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .DW(DW), .SECOND(1'b0)) dec_a_i (
      .mode(mode), .addr(a_addr), .tgt(a_tgt), .widx(a_widx)
   );
   wram_slot_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .DW(DW), .SECOND(1'b1)) dec_b_i (
      .mode(mode), .addr(b_addr), .tgt(b_tgt), .widx(b_widx)
   );

   logic [DW-1:0] sh_rdata [N_SH];
   logic [DW-1:0] pv_rdata [N_PV];

   generate
      for (genvar h = 0; h < N_SH; h++) begin : g_shared
         logic hit_a, hit_b;
         assign hit_a = a_en && a_tgt.kind == K_SHARED && a_tgt.bank == 2'(h);
         assign hit_b = b_en && b_tgt.kind == K_SHARED && b_tgt.bank == 2'(h);
         wram_bank #(.DW(DW), .DEPTH(DEPTH)) ram_i (
            .clk(clk),
            .en(hit_a || hit_b),
            .we(hit_a ? a_we : b_we),
            .be(hit_a ? a_be : b_be),
            .widx(hit_a ? a_widx : b_widx),
            .wdata(hit_a ? a_wdata : b_wdata),
            .rdata(sh_rdata[h])
         );
      end
      for (genvar p = 0; p < N_PV; p++) begin : g_priv
         logic hit_b;
         assign hit_b = b_en && b_tgt.kind == K_PRIV && b_tgt.bank == 2'(p);
         wram_bank #(.DW(DW), .DEPTH(DEPTH)) ram_i (
            .clk(clk), .en(hit_b), .we(b_we), .be(b_be),
            .widx(b_widx), .wdata(b_wdata), .rdata(pv_rdata[p])
         );
      end
   endgenerate

   // Remember where each port's last read went; the data comes from that bank.
   tgt_t a_sel_q, b_sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_sel_q <= '{kind: K_NONE, bank: 2'd0};
         b_sel_q <= '{kind: K_NONE, bank: 2'd0};
      end else begin
         if (a_en && !a_we) a_sel_q <= a_tgt;
         if (b_en && !b_we) b_sel_q <= b_tgt;
      end
   end

   always_comb begin
      a_rdata = '0;
      if (a_sel_q.kind == K_SHARED) a_rdata = sh_rdata[a_sel_q.bank[0]];
      b_rdata = '0;
      case (b_sel_q.kind)
         K_SHARED: b_rdata = sh_rdata[b_sel_q.bank[0]];
         K_PRIV:   b_rdata = pv_rdata[b_sel_q.bank];
         default:  b_rdata = '0;
      endcase
   end

   logic unused_bank;
   assign unused_bank = a_sel_q.bank[1];

endmodule

// File: rtl/wram_bank_mapper_chk.sv
module wram_bank_mapper_chk
   import wram_map_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int OFS_W  = 9,
   parameter int DW     = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              boot_init,
   input logic              cfg_we,
   input logic [7:0]        cfg_wdata,
   input logic [7:0]        cfg_rdata,
   input logic [7:0]        stat_rdata,
   input logic              a_en,
   input logic              a_we,
   input logic              b_en,
   input logic [ADDR_W-1:0] b_addr,
   input logic [DW-1:0]     a_rdata,
   input tgt_t              a_tgt,
   input tgt_t              b_tgt
);

   a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      (a_en && b_en && a_tgt.kind == K_SHARED && b_tgt.kind == K_SHARED)
      |-> (a_tgt.bank != b_tgt.bank));

   a_r2_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !boot_init) |=> (cfg_rdata == {6'b0, $past(cfg_wdata[1:0])}));

   a_r9_boot_mode: assert property (@(posedge clk) disable iff (!rst_n)
      boot_init |=> (cfg_rdata == 8'd3));

   a_r8_status_match: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rdata == cfg_rdata) && (cfg_rdata[7:2] == 6'b0));

   a_r6_high_private: assert property (@(posedge clk) disable iff (!rst_n)
      (b_en && b_addr[ADDR_W-1])
      |-> (b_tgt.kind == K_PRIV && b_tgt.bank == b_addr[OFS_W+1:OFS_W]));

   a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (a_en && !a_we && a_tgt.kind == K_NONE) |=> (a_rdata == '0));

   a_r4_first_mode3: assert property (@(posedge clk) disable iff (!rst_n)
      (a_en && cfg_rdata == 8'd3) |-> (a_tgt.kind == K_NONE));

endmodule

bind wram_bank_mapper wram_bank_mapper_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .DW(DW)) chk_i (
   .clk(clk), .rst_n(rst_n), .boot_init(boot_init), .cfg_we(cfg_we),
   .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .stat_rdata(stat_rdata),
   .a_en(a_en), .a_we(a_we), .b_en(b_en), .b_addr(b_addr),
   .a_rdata(a_rdata), .a_tgt(a_tgt), .b_tgt(b_tgt)
);

// File: tb/wram_bank_mapper_tb_top.sv
`timescale 1ns/1ps
module wram_bank_mapper_tb_top;

   localparam int DW     = 32;
   localparam int ADDR_W = 24;
   localparam int OFS_W  = 9;
   localparam int W0     = 5;

   // Expected target code per [mode][slot]: 0/1 shared half, 4..7 private bank, F none.
   localparam logic [3:0] MAP_A [4][4] = '{
      '{4'h0, 4'h1, 4'h0, 4'h1},
      '{4'h1, 4'h1, 4'h1, 4'h1},
      '{4'h0, 4'h0, 4'h0, 4'h0},
      '{4'hF, 4'hF, 4'hF, 4'hF}};
   localparam logic [3:0] MAP_B [4][4] = '{
      '{4'h4, 4'h5, 4'h6, 4'h7},
      '{4'h0, 4'h0, 4'h0, 4'h0},
      '{4'h1, 4'h1, 4'h1, 4'h1},
      '{4'h0, 4'h1, 4'h0, 4'h1}};

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic              rst_n = 1'b0, boot_init = 1'b0, cfg_we = 1'b0;
   logic [7:0]        cfg_wdata = '0, cfg_rdata, stat_rdata;
   logic              a_en = 1'b0, a_we = 1'b0, b_en = 1'b0, b_we = 1'b0;
   logic [3:0]        a_be = '0, b_be = '0;
   logic [ADDR_W-1:0] a_addr = '0, b_addr = '0;
   logic [DW-1:0]     a_wdata = '0, b_wdata = '0, a_rdata, b_rdata;

   wram_bank_mapper #(.DW(DW), .ADDR_W(ADDR_W), .OFS_W(OFS_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .boot_init(boot_init), .cfg_we(cfg_we),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .stat_rdata(stat_rdata),
      .a_en(a_en), .a_we(a_we), .a_be(a_be), .a_addr(a_addr), .a_wdata(a_wdata),
      .a_rdata(a_rdata), .b_en(b_en), .b_we(b_we), .b_be(b_be), .b_addr(b_addr),
      .b_wdata(b_wdata), .b_rdata(b_rdata)
   );

   int n_tests = 0, n_fail = 0;
   logic [1:0]    mode_now = 2'd0;
   logic [DW-1:0] m_sh [2];
   logic [DW-1:0] m_pv [4];

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] tgt_of(input bit pb, input bit hi, input int slot);
      if (!pb) return MAP_A[mode_now][slot];
      if (hi)  return 4'(4 + slot);
      return MAP_B[mode_now][slot];
   endfunction

   function automatic logic [DW-1:0] model_rd(input logic [3:0] code);
      if (code == 4'hF) return '0;
      if (code < 4'h4)  return m_sh[code[0]];
      return m_pv[code[1:0]];
   endfunction

   task automatic model_wr(input logic [3:0] code, input logic [3:0] be, input logic [DW-1:0] d);
      logic [DW-1:0] cur;
      if (code == 4'hF) return;
      cur = model_rd(code);
      for (int i = 0; i < 4; i++) if (be[i]) cur[i*8 +: 8] = d[i*8 +: 8];
      if (code < 4'h4) m_sh[code[0]] = cur;
      else             m_pv[code[1:0]] = cur;
   endtask

   function automatic logic [ADDR_W-1:0] addr_of(input bit hi, input int slot);
      return (ADDR_W'(hi) << (ADDR_W-1)) | (ADDR_W'(slot) << OFS_W) | ADDR_W'(W0 << 2);
   endfunction

   task automatic acc(input bit pb, input bit we, input logic [3:0] be, input bit hi,
                      input int slot, input logic [DW-1:0] d, input string req);
      logic [3:0] code;
      @(negedge clk);
      code = tgt_of(pb, hi, slot);
      if (pb) begin
         b_en = 1'b1; b_we = we; b_be = be; b_addr = addr_of(hi, slot); b_wdata = d;
      end else begin
         a_en = 1'b1; a_we = we; a_be = be; a_addr = addr_of(1'b0, slot); a_wdata = d;
      end
      @(negedge clk);
      a_en = 1'b0; b_en = 1'b0; a_we = 1'b0; b_we = 1'b0;
      if (we) model_wr(code, be, d);
      else    check(req, pb ? b_rdata : a_rdata, model_rd(code));
   endtask

   task automatic set_mode(input logic [7:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
      mode_now = v[1:0];
   endtask

   task automatic sweep();
      for (int s = 0; s < 4; s++) acc(1'b0, 1'b0, 4'hF, 1'b0, s, '0, (mode_now == 2'd3) ? "R7" : "R4");
      for (int s = 0; s < 4; s++) acc(1'b1, 1'b0, 4'hF, 1'b0, s, '0, "R5");
      for (int s = 0; s < 4; s++) acc(1'b1, 1'b0, 4'hF, 1'b1, s, '0, "R6");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset mode", {24'b0, cfg_rdata}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 mode after reset", {24'b0, cfg_rdata}, 32'd0);
      check("R8 status after reset", {24'b0, stat_rdata}, 32'd0);

      // Seed every target with a known value in mode 0.
      acc(1'b0, 1'b1, 4'hF, 1'b0, 0, 32'hA0A0_0000, "R4");
      acc(1'b0, 1'b1, 4'hF, 1'b0, 1, 32'hA1A1_0001, "R4");
      for (int s = 0; s < 4; s++) acc(1'b1, 1'b1, 4'hF, 1'b0, s, 32'hB000_0000 + s, "R5");
      acc(1'b0, 1'b1, 4'hF, 1'b0, 0, 32'h1234_5678, "R11");
      acc(1'b0, 1'b0, 4'hF, 1'b0, 0, '0, "R11 read next cycle");
      sweep();

      // Table-driven sweep of every mode, upper control bits set as noise.
      for (int m = 0; m < 4; m++) begin
         set_mode({6'b101101, 2'(m)});
         check("R2 mode low bits", {24'b0, cfg_rdata}, 32'(m));
         check("R8 status mode", {24'b0, stat_rdata}, 32'(m));
         for (int s = 0; s < 4; s++) begin
            acc(1'b0, 1'b1, 4'hF, 1'b0, s, {8'hA0, 8'(m), 8'(s), 8'h11}, "R4");
            sweep();
         end
         for (int s = 0; s < 8; s++) begin
            acc(1'b1, 1'b1, 4'hF, s >= 4, s % 4, {8'hB0, 8'(m), 8'(s), 8'h22}, "R5");
            sweep();
         end
      end

      // Byte lanes on a private bank.
      set_mode(8'd0);
      acc(1'b1, 1'b1, 4'hF, 1'b1, 2, 32'h1122_3344, "R10");
      acc(1'b1, 1'b1, 4'b0100, 1'b1, 2, 32'hAABB_CCDD, "R10");
      acc(1'b1, 1'b0, 4'hF, 1'b0, 2, '0, "R10");
      check("R10 merged lanes", m_pv[2], 32'h11BB_3344);

      // Control write in the same cycle as a read: old mode applies.
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = 8'd1;
      a_en = 1'b1; a_we = 1'b0; a_be = 4'hF; a_addr = addr_of(1'b0, 0);
      @(negedge clk);
      cfg_we = 1'b0; a_en = 1'b0;
      check("R2 same-cycle access uses old mode", a_rdata, m_sh[0]);
      mode_now = 2'd1;
      acc(1'b0, 1'b0, 4'hF, 1'b0, 0, '0, "R2 next access uses new mode");

      // Both ports in one cycle on different halves (mode 1).
      @(negedge clk);
      a_en = 1'b1; a_we = 1'b1; a_be = 4'hF; a_addr = addr_of(1'b0, 2); a_wdata = 32'hCAFE_0001;
      b_en = 1'b1; b_we = 1'b1; b_be = 4'hF; b_addr = addr_of(1'b0, 3); b_wdata = 32'hBEEF_0002;
      @(negedge clk);
      a_en = 1'b0; b_en = 1'b0; a_we = 1'b0; b_we = 1'b0;
      m_sh[1] = 32'hCAFE_0001; m_sh[0] = 32'hBEEF_0002;
      acc(1'b0, 1'b0, 4'hF, 1'b0, 0, '0, "R3 port A half 1");
      acc(1'b1, 1'b0, 4'hF, 1'b0, 1, '0, "R3 port B half 0");
      check("R3 half 1 value", m_sh[1], 32'hCAFE_0001);

      // Boot input wins over a simultaneous control write.
      set_mode(8'd2);
      @(negedge clk);
      boot_init = 1'b1; cfg_we = 1'b1; cfg_wdata = 8'd1;
      @(negedge clk);
      boot_init = 1'b0; cfg_we = 1'b0;
      mode_now = 2'd3;
      check("R9 boot mode", {24'b0, cfg_rdata}, 32'd3);
      check("R8 boot status", {24'b0, stat_rdata}, 32'd3);
      acc(1'b0, 1'b1, 4'hF, 1'b0, 1, 32'hDEAD_DEAD, "R7");
      acc(1'b0, 1'b0, 4'hF, 1'b0, 1, '0, "R7 unmapped read zero");
      acc(1'b1, 1'b0, 4'hF, 1'b0, 1, '0, "R7 half 1 unchanged");
      acc(1'b1, 1'b0, 4'hF, 1'b0, 0, '0, "R5 boot mode half 0");

      // Reset again clears the mode.
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 mode after second reset", {24'b0, cfg_rdata}, 32'd0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule